// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page translations. Each lookup presents a virtual address, the identifier of the address space that is currently running, and the current privilege level. Every stored entry is compared against the lookup in parallel. An entry matches only when its virtual page number and its 8-bit address-space tag both equal the request. One cycle later the block returns a physical address, a permission fault, or a refill exception. Pages are a fixed 4 KB. The physical frame number is wider than the virtual page number, so the physical address space is larger than the virtual one.

The block never walks page tables. When a lookup misses, it raises a refill exception, and privileged software writes the missing translation through a write port, at an index the software chooses. To help with that refill, a free-running LFSR offers a random victim index. That index never falls among the lowest `WIRED` entries, so those entries stay pinned. Writes are honoured only in kernel mode. If more than one entry matches, the lowest index supplies the translation and an error flag is raised.

Top module: `tlb_asid_cam`

## Requirements
- R1: Each cycle with `lk_valid` high produces exactly one response in the next cycle, with `rsp_valid` high. `rsp_valid` is low in every cycle that follows a cycle with `lk_valid` low.
- R2: A lookup hits when a stored entry meets all three conditions: its valid bit is set, its page number equals `lk_vaddr[31:12]`, and its tag equals `lk_asid`. On a hit, `rsp_paddr` equals the entry frame number concatenated with `lk_vaddr[11:0]`. On any response that is not a hit, `rsp_paddr` is zero.
- R3: Privilege codes are user=0, supervisor=1 and kernel=2. An entry's access level uses the same encoding and gives the lowest mode allowed to use it. A matching entry whose level is above `lk_mode` gives `rsp_fault`=1 and `rsp_hit`=0.
- R4: A lookup that matches no entry gives `rsp_refill`=1, `rsp_hit`=0 and `rsp_fault`=0.
- R5: A write with `wr_en`=1 updates entry `wr_idx` only when `wr_mode` is kernel (2). In any other mode the write has no effect, and `wr_priv_err` is high in the following cycle.
- R6: `rand_idx` always lies in the range WIRED to NUM_ENTRIES-1. Over a long run, every index in that range appears.
- R7: When several entries match, the entry with the lowest index supplies the frame and the permission check, and `rsp_multi` is 1.
- R8: An entry written with `wr_valid`=0 never hits, even if its page number and tag match the lookup.
- R9: After reset, every entry is invalid, and `rsp_valid`, `rsp_hit` and `wr_priv_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_asid | input | 8 | Current address-space tag |
| lk_mode | input | 2 | Privilege of the access (0 user, 1 supervisor, 2 kernel) |
| wr_en | input | 1 | Entry write request |
| wr_idx | input | $clog2(NUM_ENTRIES) | Entry to write |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_asid | input | 8 | Tag to store |
| wr_pfn | input | 24 | Physical frame number to store |
| wr_perm | input | 2 | Lowest privilege allowed to use the entry |
| wr_valid | input | 1 | Valid bit to store |
| wr_mode | input | 2 | Privilege of the writer |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_paddr | output | 36 | Physical address |
| rsp_fault | output | 1 | Permission fault |
| rsp_refill | output | 1 | Miss: software refill needed |
| rsp_multi | output | 1 | More than one entry matched |
| wr_priv_err | output | 1 | Previous write was refused |
| rand_idx | output | $clog2(NUM_ENTRIES) | Suggested replacement index |

## Verification
The bench drives random writes and lookups over a small pool of page numbers and tags, so that tag-only differences, duplicate entries and disallowed modes come up often. Each result is checked against a reference model kept in the bench. Directed cases then cover the following faults:
- A design that ignored the tag would hit across address spaces.
- A design that ignored the valid bit would hit on a cleared entry.
- A design that picked the highest matching index would return the wrong frame on a duplicate.
- A design that accepted user-mode writes would later hit on a translation that should not exist.
- A design with an off-by-one in the privilege compare would fault a supervisor access to a supervisor page.

The frame used in the tests sets its top bit, so a truncated physical address shows up. The random index is sampled over many cycles for values below the wired count and for any index that never appears.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int VA_W     = 32;
    localparam int OFF_W    = 12;
    localparam int VPN_W    = VA_W - OFF_W;
    localparam int PFN_W    = 24;
    localparam int PA_W     = PFN_W + OFF_W;
    localparam int ASID_W   = 8;
    localparam int MODE_W   = 2;
    localparam int LFSR_W   = 16;

    typedef enum logic [MODE_W-1:0] {
        PRV_USER   = 2'd0,
        PRV_SUPER  = 2'd1,
        PRV_KERNEL = 2'd2,
        PRV_RSVD   = 2'd3
    } prv_e;

    typedef struct packed {
        logic                valid;
        logic [MODE_W-1:0]   perm;
        logic [ASID_W-1:0]   asid;
        logic [VPN_W-1:0]    vpn;
        logic [PFN_W-1:0]    pfn;
    } tlb_entry_t;

    // Access is allowed when the requesting mode is at least the entry level.
    function automatic logic access_ok(input logic [MODE_W-1:0] mode,
                                       input logic [MODE_W-1:0] level);
        return mode >= level;
    endfunction

    function automatic logic write_ok(input logic [MODE_W-1:0] mode);
        return mode == PRV_KERNEL;
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlbx_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [IDX_W-1:0]              widx,
    input  tlb_entry_t                    wdata,
    input  logic [VPN_W-1:0]              cmp_vpn,
    input  logic [ASID_W-1:0]             cmp_asid,
    output logic [NUM_ENTRIES-1:0]        match_vec,
    output tlb_entry_t [NUM_ENTRIES-1:0]  ents
);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[g] <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                ents[g] <= wdata;
            end
        end

        assign match_vec[g] = ents[g].valid
                            && (ents[g].vpn  == cmp_vpn)
                            && (ents[g].asid == cmp_asid);
    end

endmodule

// File: rtl/tlb_match_pick.sv
module tlb_match_pick #(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] match_vec,
    output logic                   any,
    output logic                   multi,
    output logic [IDX_W-1:0]       idx
);

    always_comb begin
        idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign any   = |match_vec;
    assign multi = |(match_vec & (match_vec - 1'b1));

endmodule

// File: rtl/tlb_rand_gen.sv
module tlb_rand_gen
    import tlbx_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int WIRED       = 4,
    parameter int SEED        = 16'hACE1,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] rand_idx
);

    localparam int SPAN = NUM_ENTRIES - WIRED;

    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= LFSR_W'(SEED);
        end else begin
            lfsr_q <= lfsr_step(lfsr_q);
        end
    end

    assign pos      = (lfsr_q % LFSR_W'(SPAN)) + LFSR_W'(WIRED);
    assign rand_idx = pos[IDX_W-1:0];

endmodule

// File: rtl/tlb_asid_cam.sv
module tlb_asid_cam
    import tlbx_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int WIRED       = 4,
    parameter int LFSR_SEED   = 16'hACE1,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   lk_valid,
    input  logic [VA_W-1:0]        lk_vaddr,
    input  logic [ASID_W-1:0]      lk_asid,
    input  logic [MODE_W-1:0]      lk_mode,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [VPN_W-1:0]       wr_vpn,
    input  logic [ASID_W-1:0]      wr_asid,
    input  logic [PFN_W-1:0]       wr_pfn,
    input  logic [MODE_W-1:0]      wr_perm,
    input  logic                   wr_valid,
    input  logic [MODE_W-1:0]      wr_mode,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic [PA_W-1:0]        rsp_paddr,
    output logic                   rsp_fault,
    output logic                   rsp_refill,
    output logic                   rsp_multi,
    output logic                   wr_priv_err,
    output logic [IDX_W-1:0]       rand_idx
);

    tlb_entry_t                   wdata;
    tlb_entry_t [NUM_ENTRIES-1:0] ents;
    tlb_entry_t                   sel;
    logic [NUM_ENTRIES-1:0]       match_vec;
    logic                         any_m, multi_m, allowed, wr_go;
    logic [IDX_W-1:0]             pick;
    logic                         hit_d, fault_d, refill_d, multi_d;
    logic [PA_W-1:0]              paddr_d;

    assign wr_go = wr_en && write_ok(wr_mode);

    always_comb begin
        wdata       = '0;
        wdata.valid = wr_valid;
        wdata.perm  = wr_perm;
        wdata.asid  = wr_asid;
        wdata.vpn   = wr_vpn;
        wdata.pfn   = wr_pfn;
    end

    tlb_entry_array #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_arr (
        .clk       (clk),
        .rst       (rst),
        .we        (wr_go),
        .widx      (wr_idx),
        .wdata     (wdata),
        .cmp_vpn   (lk_vaddr[VA_W-1:OFF_W]),
        .cmp_asid  (lk_asid),
        .match_vec (match_vec),
        .ents      (ents)
    );

    tlb_match_pick #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick (
        .match_vec (match_vec),
        .any       (any_m),
        .multi     (multi_m),
        .idx       (pick)
    );

    tlb_rand_gen #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .WIRED       (WIRED),
        .SEED        (LFSR_SEED),
        .IDX_W       (IDX_W)
    ) u_rand (
        .clk      (clk),
        .rst      (rst),
        .rand_idx (rand_idx)
    );

    assign sel     = ents[pick];
    assign allowed = access_ok(lk_mode, sel.perm);

    always_comb begin
        hit_d    = lk_valid && any_m && allowed;
        fault_d  = lk_valid && any_m && !allowed;
        refill_d = lk_valid && !any_m;
        multi_d  = lk_valid && multi_m;
        paddr_d  = hit_d ? {sel.pfn, lk_vaddr[OFF_W-1:0]} : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_fault   <= 1'b0;
            rsp_refill  <= 1'b0;
            rsp_multi   <= 1'b0;
            rsp_paddr   <= '0;
            wr_priv_err <= 1'b0;
        end else begin
            rsp_valid   <= lk_valid;
            rsp_hit     <= hit_d;
            rsp_fault   <= fault_d;
            rsp_refill  <= refill_d;
            rsp_multi   <= multi_d;
            rsp_paddr   <= paddr_d;
            wr_priv_err <= wr_en && !write_ok(wr_mode);
        end
    end

endmodule

// File: rtl/tlb_asid_cam_chk.sv
module tlb_asid_cam_chk
    import tlbx_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int WIRED       = 4,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic              wr_en,
    input logic [MODE_W-1:0] wr_mode,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_fault,
    input logic              rsp_refill,
    input logic              rsp_multi,
    input logic              wr_priv_err,
    input logic [IDX_W-1:0]  rand_idx
);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid); // R1

    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid); // R1

    AST_FAULT_NOT_HIT: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_valid && !rsp_hit && !rsp_refill); // R3

    AST_REFILL_ALONE: assert property (@(posedge clk) disable iff (rst)
        rsp_refill |-> rsp_valid && !rsp_hit && !rsp_fault && !rsp_multi); // R4

    AST_WRITE_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mode != PRV_KERNEL) |=> wr_priv_err); // R5

    AST_WRITE_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mode == PRV_KERNEL) |=> !wr_priv_err); // R5

    AST_RAND_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (int'(rand_idx) >= WIRED) && (int'(rand_idx) < NUM_ENTRIES)); // R6

    AST_MULTI_HAS_MATCH: assert property (@(posedge clk) disable iff (rst)
        rsp_multi |-> (rsp_hit || rsp_fault)); // R7

endmodule

bind tlb_asid_cam tlb_asid_cam_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .WIRED       (WIRED)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lk_valid    (lk_valid),
    .wr_en       (wr_en),
    .wr_mode     (wr_mode),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_fault   (rsp_fault),
    .rsp_refill  (rsp_refill),
    .rsp_multi   (rsp_multi),
    .wr_priv_err (wr_priv_err),
    .rand_idx    (rand_idx)
);

// File: tb/sim_tlb_asid_cam.sv
module sim_tlb_asid_cam;
    import tlbx_pkg::*;

    localparam int N     = 16;
    localparam int WIRED = 4;
    localparam int IDX_W = $clog2(N);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lk_valid = 1'b0;
    logic [VA_W-1:0]   lk_vaddr = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic [MODE_W-1:0] lk_mode = '0;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [VPN_W-1:0]  wr_vpn = '0;
    logic [ASID_W-1:0] wr_asid = '0;
    logic [PFN_W-1:0]  wr_pfn = '0;
    logic [MODE_W-1:0] wr_perm = '0;
    logic              wr_valid = 1'b0;
    logic [MODE_W-1:0] wr_mode = '0;
    logic              rsp_valid, rsp_hit, rsp_fault, rsp_refill, rsp_multi, wr_priv_err;
    logic [PA_W-1:0]   rsp_paddr;
    logic [IDX_W-1:0]  rand_idx;

    always #5 clk = ~clk;

    tlb_asid_cam #(.NUM_ENTRIES(N), .WIRED(WIRED)) u0 (.*);

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Bench reference model
    logic              m_v    [N];
    logic [MODE_W-1:0] m_perm [N];
    logic [ASID_W-1:0] m_asid [N];
    logic [VPN_W-1:0]  m_vpn  [N];
    logic [PFN_W-1:0]  m_pfn  [N];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input int idx, input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                            input logic [PFN_W-1:0] pfn, input logic [MODE_W-1:0] perm,
                            input logic v, input logic [MODE_W-1:0] mode);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_vpn = vpn; wr_asid = asid;
        wr_pfn = pfn; wr_perm = perm; wr_valid = v; wr_mode = mode;
        @(negedge clk);
        wr_en = 1'b0;
        chk(wr_priv_err == (mode != PRV_KERNEL), "R5 priv_err", wr_priv_err, mode != PRV_KERNEL);
        if (mode == PRV_KERNEL) begin
            m_v[idx] = v; m_perm[idx] = perm; m_asid[idx] = asid;
            m_vpn[idx] = vpn; m_pfn[idx] = pfn;
        end
    endtask

    task automatic do_lookup(input logic [VA_W-1:0] va, input logic [ASID_W-1:0] asid,
                             input logic [MODE_W-1:0] mode, input string req);
        int first = -1;
        int cnt = 0;
        logic e_hit, e_fault, e_ref, e_multi;
        logic [PA_W-1:0] e_pa;
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_vpn[i] == va[VA_W-1:OFF_W] && m_asid[i] == asid) begin
                if (first < 0) first = i;
                cnt++;
            end
        end
        e_ref   = (first < 0);
        e_hit   = (first >= 0) && (mode >= m_perm[first]);
        e_fault = (first >= 0) && !(mode >= m_perm[first]);
        e_multi = (cnt > 1);
        e_pa    = e_hit ? {m_pfn[first], va[OFF_W-1:0]} : '0;
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_mode = mode;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(rsp_valid == 1'b1, {req, " R1 valid"}, rsp_valid, 1);
        chk(rsp_hit == e_hit, {req, " R2 hit"}, rsp_hit, e_hit);
        chk(rsp_paddr == e_pa, {req, " R2 paddr"}, rsp_paddr, e_pa);
        chk(rsp_fault == e_fault, {req, " R3 fault"}, rsp_fault, e_fault);
        chk(rsp_refill == e_ref, {req, " R4 refill"}, rsp_refill, e_ref);
        chk(rsp_multi == e_multi, {req, " R7 multi"}, rsp_multi, e_multi);
    endtask

    function automatic logic [VPN_W-1:0] pool_vpn(input int k);
        return VPN_W'(32'h10000 + k * 32'h111);
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit seen [N];
        bit below;
        void'($urandom(32'd152));
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_perm[i] = 0; m_asid[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(rsp_valid == 0, "R9 rsp_valid", rsp_valid, 0);
        chk(rsp_hit == 0, "R9 rsp_hit", rsp_hit, 0);
        chk(wr_priv_err == 0, "R9 priv_err", wr_priv_err, 0);
        // R1 no response without request
        @(negedge clk);
        chk(rsp_valid == 0, "R1 idle", rsp_valid, 0);
        do_lookup({pool_vpn(0), 12'h123}, 8'd1, PRV_KERNEL, "R9 empty");

        // R2 wide frame, tag mismatch
        do_write(5, pool_vpn(1), 8'd7, 24'hF00ABC, PRV_USER, 1'b1, PRV_KERNEL);
        do_lookup({pool_vpn(1), 12'hFED}, 8'd7, PRV_USER, "R2 wide");
        do_lookup({pool_vpn(1), 12'hFED}, 8'd8, PRV_USER, "R2 tag miss");

        // R3 privilege boundaries
        do_write(6, pool_vpn(2), 8'd7, 24'h000123, PRV_SUPER, 1'b1, PRV_KERNEL);
        do_lookup({pool_vpn(2), 12'h001}, 8'd7, PRV_SUPER, "R3 super ok");
        do_lookup({pool_vpn(2), 12'h001}, 8'd7, PRV_USER, "R3 user fault");
        do_write(7, pool_vpn(3), 8'd7, 24'h000456, PRV_KERNEL, 1'b1, PRV_KERNEL);
        do_lookup({pool_vpn(3), 12'h002}, 8'd7, PRV_SUPER, "R3 super fault");
        do_lookup({pool_vpn(3), 12'h002}, 8'd7, PRV_KERNEL, "R3 kernel ok");

        // R7 duplicate: lowest index wins
        do_write(12, pool_vpn(4), 8'd9, 24'h0000AA, PRV_USER, 1'b1, PRV_KERNEL);
        do_write(3,  pool_vpn(4), 8'd9, 24'h0000BB, PRV_USER, 1'b1, PRV_KERNEL);
        do_lookup({pool_vpn(4), 12'h010}, 8'd9, PRV_USER, "R7 dup");
        chk(rsp_paddr[PA_W-1:OFF_W] == 24'h0000BB, "R7 lowest", rsp_paddr[PA_W-1:OFF_W], 24'hBB);

        // R8 invalidated entry never hits
        do_write(3, pool_vpn(4), 8'd9, 24'h0000BB, PRV_USER, 1'b0, PRV_KERNEL);
        do_write(12, pool_vpn(4), 8'd9, 24'h0000AA, PRV_USER, 1'b0, PRV_KERNEL);
        do_lookup({pool_vpn(4), 12'h010}, 8'd9, PRV_KERNEL, "R8 cleared");
        chk(rsp_hit == 0, "R8 no hit", rsp_hit, 0);

        // R5 refused write leaves no translation
        do_write(9, pool_vpn(6), 8'd2, 24'h777777, PRV_USER, 1'b1, PRV_USER);
        do_write(9, pool_vpn(6), 8'd2, 24'h777777, PRV_USER, 1'b1, PRV_SUPER);
        do_lookup({pool_vpn(6), 12'h000}, 8'd2, PRV_KERNEL, "R5 ignored");
        chk(rsp_refill == 1, "R5 refill after refused", rsp_refill, 1);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(0, 2) == 0) begin
                do_write(int'($urandom_range(0, N - 1)), pool_vpn(int'($urandom_range(0, 7))),
                         ASID_W'($urandom_range(1, 3)), PFN_W'($urandom()),
                         MODE_W'($urandom_range(0, 2)), ($urandom_range(0, 9) != 0),
                         ($urandom_range(0, 5) == 0) ? MODE_W'($urandom_range(0, 1)) : PRV_KERNEL);
            end else begin
                do_lookup({pool_vpn(int'($urandom_range(0, 7))), 12'($urandom())},
                          ASID_W'($urandom_range(1, 3)), MODE_W'($urandom_range(0, 2)), "rand");
            end
        end

        // R6 random index range and coverage
        below = 0;
        for (int i = 0; i < N; i++) seen[i] = 0;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (int'(rand_idx) < WIRED) below = 1;
            seen[rand_idx] = 1;
        end
        chk(!below, "R6 below wired", below, 0);
        for (int i = WIRED; i < N; i++) begin
            chk(seen[i], "R6 coverage", i, 1);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule